// File: doc/BRIEF.md
# Serial Flash Status and Write-Protect Controller

This block holds the status byte of a serial NOR flash and acts as the gatekeeper for every write-type command. A command decoder presents single-cycle strobes for write enable, write disable, status write, page program, sector erase, block erase and chip erase. It also supplies the target address and the level of the hardware write-protect pin. The block answers each write-type strobe with a one-cycle grant or deny pulse. A grant also carries an operation code that tells the array sequencer what to run.

A grant sets the busy bit. The array later reports completion with a one-cycle done pulse, which clears both the busy bit and the write-enable latch. Three protect bits select a protected region. The region always ends at the top of the array and covers 1, 2, 4, 8, 16 or all 32 of the 64 KB blocks. A status-lock bit, together with a low write-protect pin, freezes the non-volatile status fields. A power-up timer blocks all writes for a fixed number of cycles after reset.

Top module: `flash_wp_ctrl`

## Requirements
- R1: During and directly after reset, the status byte reads 00h, grant and deny are low and the operation code is 0.
- R2: Status bit 0 is busy, bit 1 is the write-enable latch, bits 4..2 are the protect field and bit 7 is the status lock; bits 6..5 always read 0.
- R3: Outside a busy period, a write-enable strobe sets bit 1 and a write-disable strobe clears it, in the cycle after the strobe.
- R4: A write-type command (status write, page program, sector erase, block erase, chip erase) that arrives while bit 1 is 0 is denied. Any deny pulse leaves bit 1 cleared.
- R5: For PWRUP_CYC cycles after reset is released, every write-type command is denied. Write enable and write disable still work during this time.
- R6: The target block is address bits 20..16. Protect field 000 protects no block; 001 protects block 31; 010 protects blocks 30–31; 011 protects 28–31; 100 protects 24–31; 101 protects 16–31; 110 and 111 protect all blocks. A page program, sector erase or block erase aimed at a protected block is denied.
- R7: A chip erase is granted only when the protect field is 000.
- R8: A status write is denied when bit 7 is 1 and the write-protect pin is low. With bit 7 at 0, the pin level has no effect on a status write.
- R9: A granted status write loads bit 7 and bits 4..2 from data bits 7 and 4..2. It ignores data bits 6..5 and 1..0.
- R10: A granted command gives a one-cycle grant pulse in the cycle after the strobe, with bit 0 set and an operation code of 1 (page program), 2 (sector erase), 3 (block erase), 4 (chip erase) or 5 (status write). A done pulse while bit 0 is 1 clears bits 0 and 1 in the next cycle.
- R11: While bit 0 is 1, all command strobes are ignored: no grant, no deny and no status change. A done pulse while bit 0 is 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wren_i | input | 1 | Write-enable strobe |
| wrdi_i | input | 1 | Write-disable strobe |
| wrsr_i | input | 1 | Status-write strobe |
| wrsr_data_i | input | 8 | Data byte for a status write |
| pp_i | input | 1 | Page-program strobe |
| se_i | input | 1 | Sector-erase strobe |
| be_i | input | 1 | Block-erase strobe |
| ce_i | input | 1 | Chip-erase strobe |
| addr_i | input | ADDR_W | Target byte address |
| wp_n_i | input | 1 | Hardware write-protect pin, active low |
| arr_done_i | input | 1 | Array operation finished |
| status_o | output | 8 | Status byte |
| grant_o | output | 1 | Command accepted, one cycle |
| deny_o | output | 1 | Command rejected, one cycle |
| op_o | output | 3 | Operation code of the granted command |

## Verification
On every cycle, the assertions check the relationships that hold in any state. Grant and busy rise together, grant and deny never occur together, and a deny leaves the latch clear. A busy cycle is never followed by a grant or deny. The locked status fields stay put while the lock bit is set and the pin is low. Nothing is granted inside the power-up window, and the unused bits stay zero. The bench scenarios are needed to show the region decode for each protect setting against blocks on both sides of each boundary. They also cover the masking of status-write data, the ignored done pulse, and that the pin alone does not block a status write when the lock bit is clear.

// File: rtl/fsr_pkg.sv
`timescale 1ns/1ps
package fsr_pkg;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PROG = 3'd1,
        OP_SECT = 3'd2,
        OP_BLK  = 3'd3,
        OP_CHIP = 3'd4,
        OP_WRSR = 3'd5
    } wr_op_e;

    typedef struct packed {
        logic       lock;
        logic [2:0] bp;
        logic       wel;
        logic       wip;
    } stat_t;

    typedef struct packed {
        stat_t  st;
        logic   grant;
        logic   deny;
        wr_op_e op;
    } ctl_t;

    function automatic logic [7:0] stat_byte(input stat_t s);
        return {s.lock, 2'b00, s.bp, s.wel, s.wip};
    endfunction

endpackage

// File: rtl/fsr_region_dec.sv
`timescale 1ns/1ps
module fsr_region_dec #(
    parameter int NUM_BLOCKS = 32,
    localparam int BLK_W     = $clog2(NUM_BLOCKS),
    localparam int CW        = BLK_W + 1
) (
    input  logic [2:0]       bp_i,
    input  logic [BLK_W-1:0] blk_i,
    output logic             hit_o,
    output logic             any_o
);
    logic [CW-1:0] span;
    logic [CW-1:0] low;

    // Size of the top region doubles with each step of the field, capped at the full array.
    always_comb begin
        if (bp_i == 3'd0) begin
            span = '0;
        end else if ((int'(bp_i) - 1) >= BLK_W) begin
            span = CW'(NUM_BLOCKS);
        end else begin
            span = CW'(1) << (int'(bp_i) - 1);
        end
        low   = CW'(NUM_BLOCKS) - span;
        hit_o = ({1'b0, blk_i} >= low);
        any_o = (span != '0);
    end
endmodule

// File: rtl/fsr_inhibit_tmr.sv
`timescale 1ns/1ps
module fsr_inhibit_tmr #(
    parameter int CYC    = 64,
    localparam int CNT_W = $clog2(CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    output logic ready_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != CNT_W'(CYC)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign ready_o = (cnt_q == CNT_W'(CYC));
endmodule

// File: rtl/fsr_cmd_eval.sv
`timescale 1ns/1ps
module fsr_cmd_eval
    import fsr_pkg::*;
(
    input  logic   wrsr_i,
    input  logic   pp_i,
    input  logic   se_i,
    input  logic   be_i,
    input  logic   ce_i,
    input  logic   ready_i,
    input  logic   wel_i,
    input  logic   lock_i,
    input  logic   wp_n_i,
    input  logic   blk_hit_i,
    input  logic   any_prot_i,
    output wr_op_e op_o,
    output logic   allow_o
);
    always_comb begin
        if (wrsr_i)    op_o = OP_WRSR;
        else if (ce_i) op_o = OP_CHIP;
        else if (be_i) op_o = OP_BLK;
        else if (se_i) op_o = OP_SECT;
        else if (pp_i) op_o = OP_PROG;
        else           op_o = OP_NONE;

        allow_o = ready_i && wel_i;
        unique case (op_o)
            OP_WRSR:                   if (lock_i && !wp_n_i) allow_o = 1'b0;
            OP_CHIP:                   if (any_prot_i)        allow_o = 1'b0;
            OP_PROG, OP_SECT, OP_BLK:  if (blk_hit_i)         allow_o = 1'b0;
            default:                   allow_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/flash_wp_ctrl.sv
`timescale 1ns/1ps
module flash_wp_ctrl
    import fsr_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int NUM_BLOCKS = 32,
    parameter int PWRUP_CYC  = 64,
    localparam int BLK_W     = $clog2(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic [7:0]        wrsr_data_i,
    input  logic              pp_i,
    input  logic              se_i,
    input  logic              be_i,
    input  logic              ce_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wp_n_i,
    input  logic              arr_done_i,
    output logic [7:0]        status_o,
    output logic              grant_o,
    output logic              deny_o,
    output logic [2:0]        op_o
);
    ctl_t   ctl_d, ctl_q;
    logic   ready;
    logic   blk_hit;
    logic   any_prot;
    logic   allow;
    wr_op_e req_op;

    fsr_inhibit_tmr #(.CYC(PWRUP_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ready_o (ready)
    );

    fsr_region_dec #(.NUM_BLOCKS(NUM_BLOCKS)) u_dec (
        .bp_i  (ctl_q.st.bp),
        .blk_i (addr_i[ADDR_W-1 -: BLK_W]),
        .hit_o (blk_hit),
        .any_o (any_prot)
    );

    fsr_cmd_eval u_eval (
        .wrsr_i     (wrsr_i),
        .pp_i       (pp_i),
        .se_i       (se_i),
        .be_i       (be_i),
        .ce_i       (ce_i),
        .ready_i    (ready),
        .wel_i      (ctl_q.st.wel),
        .lock_i     (ctl_q.st.lock),
        .wp_n_i     (wp_n_i),
        .blk_hit_i  (blk_hit),
        .any_prot_i (any_prot),
        .op_o       (req_op),
        .allow_o    (allow)
    );

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.grant = 1'b0;
        ctl_d.deny  = 1'b0;
        ctl_d.op    = OP_NONE;
        if (ctl_q.st.wip) begin
            // Busy: only the completion pulse is observed.
            if (arr_done_i) begin
                ctl_d.st.wip = 1'b0;
                ctl_d.st.wel = 1'b0;
            end
        end else if (req_op != OP_NONE) begin
            if (allow) begin
                ctl_d.grant  = 1'b1;
                ctl_d.op     = req_op;
                ctl_d.st.wip = 1'b1;
                if (req_op == OP_WRSR) begin
                    ctl_d.st.lock = wrsr_data_i[7];
                    ctl_d.st.bp   = wrsr_data_i[4:2];
                end
            end else begin
                ctl_d.deny   = 1'b1;
                ctl_d.st.wel = 1'b0;
            end
        end else if (wren_i) begin
            ctl_d.st.wel = 1'b1;
        end else if (wrdi_i) begin
            ctl_d.st.wel = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign status_o = stat_byte(ctl_q.st);
    assign grant_o  = ctl_q.grant;
    assign deny_o   = ctl_q.deny;
    assign op_o     = ctl_q.op;
endmodule

// File: rtl/fsr_checker.sv
`timescale 1ns/1ps
module fsr_checker #(
    parameter int PWRUP_CYC = 64,
    localparam int CNT_W    = $clog2(PWRUP_CYC + 1)
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wp_n_i,
    input logic       arr_done_i,
    input logic [7:0] status_o,
    input logic       grant_o,
    input logic       deny_o,
    input logic [2:0] op_o
);
    logic [CNT_W-1:0] win_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          win_q <= '0;
        else if (win_q != CNT_W'(PWRUP_CYC)) win_q <= win_q + 1'b1;
    end

    a_r2_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:5] == 2'b00);

    a_r10_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (status_o[0] && op_o != 3'd0 && !deny_o));

    a_r10_wip_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[0]) |-> grant_o);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[0] && arr_done_i) |=> (!status_o[0] && !status_o[1]));

    a_r4_deny_clears_wel: assert property (@(posedge clk) disable iff (!rst_n)
        deny_o |-> (!status_o[1] && op_o == 3'd0));

    a_r11_busy_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[0] |=> (!grant_o && !deny_o));

    a_r8_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[7] && !wp_n_i) |=> $stable({status_o[7], status_o[4:2]}));

    a_r5_inhibit_window: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != CNT_W'(PWRUP_CYC)) |-> !grant_o);
endmodule

bind flash_wp_ctrl fsr_checker #(.PWRUP_CYC(PWRUP_CYC)) u_fsr_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n_i     (wp_n_i),
    .arr_done_i (arr_done_i),
    .status_o   (status_o),
    .grant_o    (grant_o),
    .deny_o     (deny_o),
    .op_o       (op_o)
);

// File: tb/flash_wp_ctrl_bench.sv
`timescale 1ns/1ps
module flash_wp_ctrl_bench;

    localparam int K_NONE = 0, K_WREN = 1, K_WRDI = 2, K_DONE = 3,
                   K_PP = 4, K_SE = 5, K_BE = 6, K_CE = 7, K_WRSR = 8;

    typedef struct {
        logic [7:0] st;
        logic       g;
        logic       d;
        logic [2:0] op;
        int         due;
        string      tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wren_i = 0, wrdi_i = 0, wrsr_i = 0, pp_i = 0, se_i = 0, be_i = 0, ce_i = 0;
    logic [7:0]  wrsr_data_i = '0;
    logic [20:0] addr_i = '0;
    logic        wp_n_i = 1'b1;
    logic        arr_done_i = 1'b0;
    logic [7:0]  status_o;
    logic        grant_o, deny_o;
    logic [2:0]  op_o;

    int    cyc = 0;
    int    total = 0;
    int    bad = 0;
    bit    over = 0;
    item_t exp_q[$];

    logic       e_wip = 0, e_wel = 0, e_lock = 0, warm = 0;
    logic [2:0] e_bp = '0;

    flash_wp_ctrl u_flash_wp_ctrl (
        .clk(clk), .rst_n(rst_n), .wren_i(wren_i), .wrdi_i(wrdi_i),
        .wrsr_i(wrsr_i), .wrsr_data_i(wrsr_data_i), .pp_i(pp_i), .se_i(se_i),
        .be_i(be_i), .ce_i(ce_i), .addr_i(addr_i), .wp_n_i(wp_n_i),
        .arr_done_i(arr_done_i), .status_o(status_o), .grant_o(grant_o),
        .deny_o(deny_o), .op_o(op_o)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every due item half a cycle after the edge.
    always @(negedge clk) begin
        while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            item_t it;
            it = exp_q.pop_front();
            total++;
            if (status_o !== it.st || grant_o !== it.g || deny_o !== it.d || op_o !== it.op) begin
                bad++;
                $display("FAIL %s: got st=%h g=%b d=%b op=%0d, expected st=%h g=%b d=%b op=%0d",
                         it.tag, status_o, grant_o, deny_o, op_o, it.st, it.g, it.d, it.op);
            end
        end
    end

    // Protected-region table from R6.
    function automatic logic prot(input logic [2:0] bp, input logic [4:0] blk);
        case (bp)
            3'd0:    return 1'b0;
            3'd1:    return blk >= 5'd31;
            3'd2:    return blk >= 5'd30;
            3'd3:    return blk >= 5'd28;
            3'd4:    return blk >= 5'd24;
            3'd5:    return blk >= 5'd16;
            default: return 1'b1;
        endcase
    endfunction

    // Driver: computes the expected outcome, drives one strobe cycle, queues the item.
    task automatic wr(input int kind, input logic [20:0] a, input logic [7:0] dat, input string tag);
        item_t it;
        logic  ok;
        it.g = 0; it.d = 0; it.op = 3'd0;
        if (e_wip) begin
            if (kind == K_DONE) begin e_wip = 0; e_wel = 0; end
        end else if (kind >= K_PP) begin
            ok = warm && e_wel;
            if (kind == K_WRSR && e_lock && !wp_n_i) ok = 0;
            if (kind >= K_PP && kind <= K_BE && prot(e_bp, a[20:16])) ok = 0;
            if (kind == K_CE && e_bp != 3'd0) ok = 0;
            if (ok) begin
                it.g = 1; it.op = 3'(kind - 3); e_wip = 1;
                if (kind == K_WRSR) begin e_lock = dat[7]; e_bp = dat[4:2]; end
            end else begin
                it.d = 1; e_wel = 0;
            end
        end else if (kind == K_WREN) begin
            e_wel = 1;
        end else if (kind == K_WRDI) begin
            e_wel = 0;
        end
        it.st  = {e_lock, 2'b00, e_bp, e_wel, e_wip};
        it.due = cyc + 1;
        it.tag = tag;
        addr_i = a; wrsr_data_i = dat;
        wren_i = (kind == K_WREN); wrdi_i = (kind == K_WRDI);
        arr_done_i = (kind == K_DONE);
        pp_i = (kind == K_PP); se_i = (kind == K_SE); be_i = (kind == K_BE);
        ce_i = (kind == K_CE); wrsr_i = (kind == K_WRSR);
        exp_q.push_back(it);
        @(negedge clk);
        wren_i = 0; wrdi_i = 0; arr_done_i = 0; pp_i = 0; se_i = 0;
        be_i = 0; ce_i = 0; wrsr_i = 0;
    endtask

    initial begin
        int blks[10] = '{0, 15, 16, 23, 24, 27, 28, 29, 30, 31};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wr(K_NONE, '0, '0, "R1 reset state");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_PP, '0, '0, "R5 program in inhibit window");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_WRSR, '0, 8'h80, "R5 status write in inhibit window");
        repeat (70) @(negedge clk);
        warm = 1;
        wr(K_PP, '0, '0, "R4 program without latch");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_WRDI, '0, '0, "R3 clear latch");
        wr(K_SE, '0, '0, "R4 erase without latch");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_WRSR, '0, 8'hFF, "R9 status write all ones");
        wr(K_WRDI, '0, '0, "R11 disable while busy");
        wr(K_PP, '0, '0, "R11 program while busy");
        wr(K_DONE, '0, '0, "R10 done clears busy");
        wr(K_DONE, '0, '0, "R11 idle done ignored");
        wr(K_NONE, '0, '0, "R2 layout after lock set");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_CE, '0, '0, "R7 chip erase protected");
        wp_n_i = 1'b0;
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_WRSR, '0, 8'h00, "R8 locked status write");
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_PP, 21'h001234, '0, "R6 all blocks protected");
        wp_n_i = 1'b1;
        wr(K_WREN, '0, '0, "R3 set latch");
        wr(K_WRSR, '0, 8'h63, "R9 masked status write");
        wr(K_DONE, '0, '0, "R10 done");
        for (int bp = 0; bp < 8; bp++) begin
            wp_n_i = bp[0];
            wr(K_WREN, '0, '0, "R3 set latch");
            wr(K_WRSR, '0, 8'(bp << 2), "R8 status write with lock clear");
            wr(K_DONE, '0, '0, "R10 done");
            for (int i = 0; i < 10; i++) begin
                wr(K_WREN, '0, '0, "R3 set latch");
                wr(K_PP + (i % 3), {5'(blks[i]), 16'h0123}, '0, "R6 region decode");
                if (e_wip) wr(K_DONE, '0, '0, "R10 done after grant");
            end
            wr(K_WREN, '0, '0, "R3 set latch");
            wr(K_CE, '0, '0, "R7 chip erase");
            if (e_wip) wr(K_DONE, '0, '0, "R10 done after chip erase");
        end
        repeat (3) @(negedge clk);
        if (!over) begin
            over = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000 && !over) begin
            over = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule